// File: doc/BRIEF.md
# Power-management interrupt aggregator

The aggregator collects seven power-management event lines into a single level-sensitive interrupt for a parent interrupt controller. Each event line is watched for a rising edge. When a rising edge arrives it sets a bit in a pending-event register. A second register holds one enable per source. The interrupt output stays high while any pending bit has its enable set.

Software reaches both registers over a simple synchronous register bus. The pending register is plain read-write: every written bit takes the written value, so a 1 raises an interrupt and a 0 clears it. Software therefore clears a pending source with a read-modify-write. That leaves a window in which a new event may arrive. The block closes that window on the hardware side: an event that lands in the same cycle as a clearing write survives the write.

Top module: `pm_irq_agg`

## Requirements
- R1: After reset, the pending register and the enable register are both zero, `irq_o` is low and `bus_rdata` is zero.
- R2: A rising edge on `evt_i[n]` sets pending bit n at the next clock edge. A level held high does not set the bit again after software has cleared it.
- R3: A write to offset 0x50 loads pending bits 6:0 with `bus_wdata[6:0]`. A written 1 sets the bit and a written 0 clears it.
- R4: A write to offset 0x54 loads enable bits 6:0 with `bus_wdata[6:0]`. An enable bit of 1 admits its source and 0 blocks it.
- R5: `irq_o` is high exactly when some pending bit has its enable bit set. It follows each register update in the same cycle that the update becomes visible.
- R6: If a rising edge on source n and a bus write of 0 to pending bit n share a clock edge, pending bit n ends up set.
- R7: Bits 31:7 of both registers read as zero, and writing them has no effect on any readable state.
- R8: A read (`bus_sel`=1, `bus_wr`=0) returns the addressed register on `bus_rdata` one cycle later. Addresses other than 0x50 and 0x54 return zero. `bus_rdata` holds its value between reads.
- R9: Clearing an enable bit does not clear the pending bit, and the pending bit can still be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Power-management event lines, rising-edge sensitive |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
Event capture and a software write to the pending register can fall on the same clock edge. That collision is the race the read-modify-write clearing scheme is exposed to. The bench provokes it in a directed case: a fresh rising edge on one source coincides with a write of zero to the whole pending register. The bench also provokes it many times in a seeded random mix of event toggles and bus writes. Each outcome is judged against a bench model in which the event bit is ORed in after the written value, and against a read-back of the pending register in the following cycles.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;

    localparam int PKG_NUM_SRC = 7;
    localparam int PKG_DATA_W  = 32;
    localparam int PKG_ADDR_W  = 8;

    localparam logic [PKG_ADDR_W-1:0] PEND_OFS = 8'h50;
    localparam logic [PKG_ADDR_W-1:0] ENAB_OFS = 8'h54;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PEND = 2'd1,
        TGT_ENAB = 2'd2
    } reg_tgt_e;

    typedef struct packed {
        logic                   valid;
        logic                   write;
        reg_tgt_e               target;
        logic [PKG_NUM_SRC-1:0] data;
    } bus_req_t;

    function automatic reg_tgt_e decode_tgt(input logic [PKG_ADDR_W-1:0] addr);
        reg_tgt_e t;
        if (addr == PEND_OFS)      t = TGT_PEND;
        else if (addr == ENAB_OFS) t = TGT_ENAB;
        else                       t = TGT_NONE;
        return t;
    endfunction

endpackage

// File: rtl/pm_irq_edge.sv
module pm_irq_edge #(
    parameter int NUM_SRC = pm_irq_pkg::PKG_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] rise_o
);
    logic [NUM_SRC-1:0] evt_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) evt_q[i] <= 1'b0;
            else     evt_q[i] <= evt_i[i];
        end
        assign rise_o[i] = evt_i[i] & ~evt_q[i];
    end
endmodule

// File: rtl/pm_irq_bank.sv
module pm_irq_bank
    import pm_irq_pkg::*;
#(
    parameter int NUM_SRC = PKG_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] rise,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] enab_q
);
    logic               pend_we;
    logic               enab_we;
    logic [NUM_SRC-1:0] pend_base;
    logic [NUM_SRC-1:0] pend_nxt;

    always_comb begin
        pend_we = req.valid && req.write && (req.target == TGT_PEND);
        enab_we = req.valid && req.write && (req.target == TGT_ENAB);
    end

    // Hardware events are merged after the software value, so they win a collision.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        assign pend_base[i] = pend_we ? req.data[i] : pend_q[i];
        assign pend_nxt[i]  = pend_base[i] | rise[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            enab_q <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (enab_we) enab_q <= req.data;
        end
    end
endmodule

// File: rtl/pm_irq_rdport.sv
module pm_irq_rdport
    import pm_irq_pkg::*;
#(
    parameter int NUM_SRC = PKG_NUM_SRC,
    parameter int DATA_W  = PKG_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic [NUM_SRC-1:0] enab_q,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic               rd_en;
    logic [NUM_SRC-1:0] sel_val;

    always_comb begin
        rd_en = req.valid && !req.write;
        unique case (req.target)
            TGT_PEND: sel_val = pend_q;
            TGT_ENAB: sel_val = enab_q;
            default:  sel_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_o <= '0;
        else if (rd_en) rdata_o <= {{PAD_W{1'b0}}, sel_val};
    end
endmodule

// File: rtl/pm_irq_agg.sv
module pm_irq_agg
    import pm_irq_pkg::*;
#(
    parameter int NUM_SRC = PKG_NUM_SRC,
    parameter int ADDR_W  = PKG_ADDR_W,
    parameter int DATA_W  = PKG_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    bus_req_t           req;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        req.valid  = bus_sel;
        req.write  = bus_wr;
        req.target = decode_tgt(bus_addr);
        req.data   = bus_wdata[NUM_SRC-1:0];
    end

    pm_irq_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .rise_o(rise)
    );

    pm_irq_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .rise  (rise),
        .pend_q(cause_q),
        .enab_q(mask_q)
    );

    pm_irq_rdport #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .pend_q (cause_q),
        .enab_q (mask_q),
        .rdata_o(bus_rdata)
    );

    assign irq_o = |(cause_q & mask_q);
endmodule

// File: rtl/pm_irq_agg_chk.sv
module pm_irq_agg_chk #(
    parameter int NUM_SRC = 7,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q
);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h50);
    localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(8'h54);

    logic [NUM_SRC-1:0] evt_d;
    logic [NUM_SRC-1:0] seen_rise;
    logic               wr_pend;
    logic               wr_enab;
    logic               rd_enab;
    logic               unused_hi;

    always_ff @(posedge clk) begin
        if (rst) evt_d <= '0;
        else     evt_d <= evt_i;
    end

    assign seen_rise = evt_i & ~evt_d;
    assign wr_pend   = bus_sel && bus_wr && (bus_addr == A_PEND);
    assign wr_enab   = bus_sel && bus_wr && (bus_addr == A_ENAB);
    assign rd_enab   = bus_sel && !bus_wr && (bus_addr == A_ENAB);
    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cause_q == '0 && mask_q == '0 && !irq_o && bus_rdata == '0));

    // R2 R6
    event_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_rise != '0) |=> ((cause_q & $past(seen_rise)) == $past(seen_rise)));

    // R3
    pend_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pend && seen_rise == '0) |=> (cause_q == $past(bus_wdata[NUM_SRC-1:0])));

    // R4
    enab_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_enab |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

    // R5
    mask_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_enab && bus_wdata[NUM_SRC-1:0] == '0) |=> !irq_o);

    // R8
    enab_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_enab |=> (bus_rdata[NUM_SRC-1:0] == $past(mask_q) &&
                     bus_rdata[DATA_W-1:NUM_SRC] == '0));
endmodule

bind pm_irq_agg pm_irq_agg_chk #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .cause_q  (cause_q),
    .mask_q   (mask_q)
);

// File: tb/pm_irq_agg_bench.sv
module pm_irq_agg_bench;
    localparam int N  = 7;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_PEND = 8'h50;
    localparam logic [AW-1:0] A_ENAB = 8'h54;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  evt_i = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int total = 0;
    int bad   = 0;

    logic [N-1:0]  m_pend = '0;
    logic [N-1:0]  m_enab = '0;
    logic [N-1:0]  m_prev = '0;
    logic [DW-1:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    pm_irq_agg u_pm_irq_agg (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_i),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        if (a == A_PEND) return {{(DW-N){1'b0}}, m_pend};
        if (a == A_ENAB) return {{(DW-N){1'b0}}, m_enab};
        return '0;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, model the rising edge, compare at the next falling edge.
    task automatic step(input logic [N-1:0] ev, input logic sel, input logic wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [N-1:0] rise;
        evt_i = ev; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        rise = ev & ~m_prev;
        if (sel && !wr) m_rdata = model_read(a);
        if (sel && wr && a == A_PEND) m_pend = d[N-1:0];
        if (sel && wr && a == A_ENAB) m_enab = d[N-1:0];
        m_pend = m_pend | rise;
        m_prev = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check(irq_o == |(m_pend & m_enab), "R5 irq level", {31'd0, irq_o},
              {31'd0, |(m_pend & m_enab)});
        if (sel && !wr)
            check(bus_rdata == m_rdata, "R8 read data", bus_rdata, m_rdata);
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                             input string req);
        step(evt_i, 1'b1, 1'b0, a, '0);
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [N-1:0]  ev;
        logic [AW-1:0] a;
        int            op;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(irq_o == 1'b0, "R1 irq after reset", {31'd0, irq_o}, 32'd0);
        check(bus_rdata == '0, "R1 rdata after reset", bus_rdata, 32'd0);
        rd_expect(A_PEND, 32'h0, "R1 pending reset");
        rd_expect(A_ENAB, 32'h0, "R1 enable reset");

        // R3 pending write, R9 masked pending stays
        step('0, 1'b1, 1'b1, A_PEND, 32'h05);
        rd_expect(A_PEND, 32'h05, "R3 pending load");
        check(irq_o == 1'b0, "R9 masked pending no irq", {31'd0, irq_o}, 32'd0);

        // R4 enable write, R5 irq high
        step('0, 1'b1, 1'b1, A_ENAB, 32'h01);
        check(irq_o == 1'b1, "R4 enabled source raises irq", {31'd0, irq_o}, 32'd1);
        step('0, 1'b1, 1'b1, A_ENAB, 32'h02);
        check(irq_o == 1'b0, "R5 irq drops when disabled", {31'd0, irq_o}, 32'd0);
        rd_expect(A_PEND, 32'h05, "R9 pending kept when disabled");

        // R7 upper bits ignored
        step('0, 1'b1, 1'b1, A_PEND, 32'hFFFF_FF80);
        rd_expect(A_PEND, 32'h0, "R7 pending upper bits");
        step('0, 1'b1, 1'b1, A_ENAB, 32'hAAAA_AA80);
        rd_expect(A_ENAB, 32'h0, "R7 enable upper bits");

        // R8 unmapped address
        rd_expect(8'h10, 32'h0, "R8 unmapped read");

        // R2 edge capture and held level
        step(7'h08, 1'b0, 1'b0, '0, '0);
        rd_expect(A_PEND, 32'h08, "R2 rising edge captured");
        step(7'h08, 1'b1, 1'b1, A_PEND, 32'h0);
        step(7'h08, 1'b0, 1'b0, '0, '0);
        step(7'h08, 1'b0, 1'b0, '0, '0);
        rd_expect(A_PEND, 32'h0, "R2 held level not recaptured");

        // R6 event collides with clearing write
        step(7'h0A, 1'b1, 1'b1, A_PEND, 32'h0);
        rd_expect(A_PEND, 32'h02, "R6 event wins over clear");
        step('0, 1'b1, 1'b1, A_ENAB, 32'h02);
        check(irq_o == 1'b1, "R6 collided event raises irq", {31'd0, irq_o}, 32'd1);

        // Random mix (R2 R3 R4 R5 R6 R8 via model)
        void'($urandom(32'd1234));
        ev = evt_i;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 4) == 0) ev = ev ^ N'($urandom);
            op = $urandom % 6;
            case ($urandom % 4)
                0:       a = A_ENAB;
                1:       a = AW'($urandom);
                default: a = A_PEND;
            endcase
            case (op)
                0, 1:    step(ev, 1'b1, 1'b1, a, $urandom);
                2, 3:    step(ev, 1'b1, 1'b0, a, '0);
                default: step(ev, 1'b0, 1'b0, a, '0);
            endcase
        end
        rd_expect(A_PEND, {{(DW-N){1'b0}}, m_pend}, "R2 final pending");
        rd_expect(A_ENAB, {{(DW-N){1'b0}}, m_enab}, "R4 final enable");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule